// File: doc/BRIEF.md
# Four-Wire Display Command Sequencer

This block drives a small display controller over a serial link made of a clock, a data line, an active-low chip select and a separate command/data select line (DC). The host hands it a byte stream, one byte per handshake. Each byte carries markers for the opening byte and the closing byte of a transaction, and a flag that marks the transaction as pixel data rather than a command. The block serialises each byte most significant bit first in SPI mode 0. It holds chip select low across the whole transaction and sets DC for each byte before that byte's first clock edge.

A command transaction is an opcode followed by zero or more parameter bytes. The opcode always goes out with DC low. Parameters normally go out with DC high. A late-deassert mode, chosen per transaction, keeps DC low for the parameters as well, which some controllers need. A pixel transaction sends every byte with DC high. After reset the block first runs a power-up sequence on the display's reset line: the line is held low for a set time, released, and then a settling time elapses before the first byte is accepted.

Top module: `disp_cmd_seq`

## Requirements
- R1: After reset, `disp_rst_n` is low for RST_LOW_CYC clock cycles and then high for good; `in_ready` stays low for a further RST_HOLD_CYC cycles, and no serial activity happens before then.
- R2: The opening byte of a command transaction (`in_first`=1, `in_pix`=0) is shifted out with `disp_dc`=0.
- R3: With `late_mode`=0 at the opening byte, every later byte of that command transaction is shifted out with `disp_dc`=1.
- R4: With `late_mode`=1 at the opening byte, every later byte of that command transaction keeps `disp_dc`=0; `late_mode` is sampled only at the opening byte.
- R5: In a transaction opened with `in_pix`=1, every byte is shifted out with `disp_dc`=1.
- R6: SPI mode 0 framing: `spi_sclk` idles low, and each byte gives 8 rising edges, each high and low phase lasting HALF_CYC cycles. The first rising edge comes HALF_CYC cycles after the byte is accepted. `spi_mosi` presents bit 7 first and changes only on falling edges.
- R7: `spi_cs_n` goes low on the cycle the opening byte is accepted. It stays low through gaps between bytes, and rises HALF_CYC cycles after the last falling edge of the closing byte (`in_last`=1).
- R8: `disp_dc` changes only when no byte is being shifted, never within a byte.
- R9: A byte offered with `in_first`=0 while no transaction is open is consumed and ignored: no clock edges, `spi_cs_n` stays high.
- R10: `busy` is high from reset through the power-up sequence, and while a transaction is open or a byte is in flight; it is low otherwise.
- R11: `in_ready` is high only after the power-up sequence and while no byte is being shifted; a byte is taken on a cycle with `in_valid` and `in_ready` both high, and the next can be taken one cycle after the previous one's tail ends (17*HALF_CYC+1 cycles per byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| late_mode | input | 1 | Keep DC low for parameter bytes (sampled at opening byte) |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_first | input | 1 | Byte opens a transaction |
| in_last | input | 1 | Byte closes the transaction |
| in_pix | input | 1 | Transaction is pixel data (sampled at opening byte) |
| in_ready | output | 1 | Block can take a byte this cycle |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Chip select, active low |
| disp_dc | output | 1 | Command (0) / data (1) select |
| disp_rst_n | output | 1 | Display hardware reset, active low |
| busy | output | 1 | Power-up, open transaction or byte in flight |

## Verification
On every cycle, the assertions check the local framing rules. The serial clock stays low outside a byte, the data line is stable while the clock is high, and DC stays put while a byte is shifting. Chip select closes only at the tail of a closing byte, and the reset line is released once and never pulses again. Properties cannot show which DC level each byte carries across opcode, parameter and pixel bytes, or that late mode is latched at the opening byte. They also cannot show that a stray non-opening byte is dropped, or the exact cycle counts of the power-up and byte timing. The bench's cycle-by-cycle model and its decoded byte log show those.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_TAIL  = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    PU_LOW  = 2'd0,
    PU_HOLD = 2'd1,
    PU_DONE = 2'd2
  } pu_state_e;

  // DC level for one byte: pixel bytes are data, opening command
  // bytes are commands, parameters depend on the late mode.
  function automatic logic dc_for_byte(input logic opening,
                                       input logic pixel,
                                       input logic late);
    if (pixel)   return 1'b1;
    if (opening) return 1'b0;
    return !late;
  endfunction

  // Counter width able to hold values 0..maxval.
  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  // Clock cycles one byte occupies from acceptance to end of tail.
  function automatic int unsigned byte_cycles(input int unsigned half);
    return (2 * BYTE_W + 1) * half;
  endfunction

endpackage

// File: rtl/disp_powerup.sv
module disp_powerup
  import disp_seq_pkg::*;
#(
  parameter int unsigned LOW_CYC  = 10000,
  parameter int unsigned HOLD_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n,
  output logic ready
);

  localparam int unsigned MAXC = (LOW_CYC > HOLD_CYC) ? LOW_CYC : HOLD_CYC;
  localparam int unsigned CW   = cnt_width(MAXC);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  pu_state_e     st;
  logic [CW-1:0] cnt;
  logic          low_end;
  logic          hold_end;

  assign low_end  = (st == PU_LOW)  && (cnt == LOW_LAST);
  assign hold_end = (st == PU_HOLD) && (cnt == HOLD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PU_LOW;
      cnt <= '0;
    end else begin
      case (st)
        PU_LOW: begin
          if (low_end) begin
            st  <= PU_HOLD;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PU_HOLD: begin
          if (hold_end) begin
            st  <= PU_DONE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign rst_out_n = (st != PU_LOW);
  assign ready     = (st == PU_DONE);

  // R1: the reset line is released once and never pulses again
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n |=> rst_out_n);

  // R1: readiness follows a cycle in which the reset line was already high
  a_r1_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(rst_out_n));

endmodule

// File: rtl/disp_spi_byte_tx.sv
module disp_spi_byte_tx
  import disp_seq_pkg::*;
#(
  parameter int unsigned HALF_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] data,
  output logic              sclk,
  output logic              mosi,
  output logic              active,
  output logic              fin
);

  localparam int unsigned HW = cnt_width(HALF_CYC);
  localparam int unsigned BW = cnt_width(BYTE_W - 1);
  localparam logic [HW-1:0] H_LAST = HW'(HALF_CYC - 1);
  localparam logic [BW-1:0] B_LAST = BW'(BYTE_W - 1);

  tx_state_e         st;
  logic [HW-1:0]     hcnt;
  logic [BW-1:0]     bidx;
  logic [BYTE_W-1:0] shreg;
  logic              half_end;
  logic              rise_ev;
  logic              fall_ev;

  assign half_end = (hcnt == H_LAST);
  assign rise_ev  = (st == TX_SHIFT) && half_end && !sclk;
  assign fall_ev  = (st == TX_SHIFT) && half_end && sclk;
  assign fin      = (st == TX_TAIL) && half_end;
  assign active   = (st != TX_IDLE);
  assign mosi     = shreg[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= TX_IDLE;
      hcnt  <= '0;
      bidx  <= '0;
      shreg <= '0;
      sclk  <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (start) begin
            st    <= TX_SHIFT;
            hcnt  <= '0;
            bidx  <= '0;
            shreg <= data;
            sclk  <= 1'b0;
          end
        end
        TX_SHIFT: begin
          if (half_end) begin
            hcnt <= '0;
            if (rise_ev) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bidx == B_LAST) begin
                st <= TX_TAIL;
              end else begin
                bidx  <= bidx + BW'(1);
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
              end
            end
          end else begin
            hcnt <= hcnt + HW'(1);
          end
        end
        TX_TAIL: begin
          if (half_end) begin
            st   <= TX_IDLE;
            hcnt <= '0;
          end else begin
            hcnt <= hcnt + HW'(1);
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R6: clock idles low whenever no bit is being shifted
  a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st != TX_SHIFT) |-> !sclk);

  // R6: data line holds on a rising edge (shift happens on falling edges)
  a_r6_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> $stable(shreg));

  // R6: the tail only ends after the final bit index was reached
  a_r6_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (bidx == B_LAST));

  // R11: a new byte is never loaded while one is in flight
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active) |-> 1'b0);

endmodule

// File: rtl/disp_txn_ctrl.sv
module disp_txn_ctrl
  import disp_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic opening,
  input  logic pix_in,
  input  logic late_in,
  input  logic last_in,
  input  logic fin,
  output logic open,
  output logic dc
);

  logic late_q;
  logic pix_q;
  logic last_q;
  logic dc_next;
  logic close_ev;

  always_comb begin
    dc_next = dc_for_byte(opening,
                          opening ? pix_in  : pix_q,
                          opening ? late_in : late_q);
  end

  assign close_ev = fin && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open   <= 1'b0;
      dc     <= 1'b0;
      late_q <= 1'b0;
      pix_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (take) begin
        open   <= 1'b1;
        last_q <= last_in;
        dc     <= dc_next;
        if (opening) begin
          late_q <= late_in;
          pix_q  <= pix_in;
        end
      end else if (close_ev) begin
        open <= 1'b0;
      end
    end
  end

  // R7: chip select window closes only at the tail of a closing byte
  a_r7_close_on_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open) |-> $past(close_ev));

  // R9: a transaction only opens from an accepted byte
  a_r9_open_by_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(take) && $past(opening));

endmodule

// File: rtl/disp_cmd_seq.sv
module disp_cmd_seq
  import disp_seq_pkg::*;
#(
  parameter int unsigned HALF_CYC     = 5,
  parameter int unsigned RST_LOW_CYC  = 10000,
  parameter int unsigned RST_HOLD_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       late_mode,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_first,
  input  logic       in_last,
  input  logic       in_pix,
  output logic       in_ready,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_cs_n,
  output logic       disp_dc,
  output logic       disp_rst_n,
  output logic       busy
);

  logic pu_ready;
  logic tx_active;
  logic tx_fin;
  logic txn_open;
  logic accept;
  logic take;

  disp_powerup #(
    .LOW_CYC  (RST_LOW_CYC),
    .HOLD_CYC (RST_HOLD_CYC)
  ) u_powerup (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_out_n (disp_rst_n),
    .ready     (pu_ready)
  );

  assign in_ready = pu_ready && !tx_active;
  assign accept   = in_valid && in_ready;
  assign take     = accept && (in_first || txn_open);

  disp_spi_byte_tx #(
    .HALF_CYC (HALF_CYC)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (take),
    .data   (in_data),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .active (tx_active),
    .fin    (tx_fin)
  );

  disp_txn_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .opening (in_first),
    .pix_in  (in_pix),
    .late_in (late_mode),
    .last_in (in_last),
    .fin     (tx_fin),
    .open    (txn_open),
    .dc      (disp_dc)
  );

  assign spi_cs_n = !txn_open;
  assign busy     = !pu_ready || tx_active || txn_open;

  // R8: DC never moves while a byte is on the wire
  a_r8_dc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> $stable(disp_dc));

  // R6: data line is stable during the high phase of the clock
  a_r6_mosi_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  // R7: chip select is asserted whenever a byte is in flight
  a_r7_cs_covers_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> !spi_cs_n);

  // R1: no serial activity before the power-up sequence finishes
  a_r1_quiet_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    !pu_ready |-> (spi_cs_n && !spi_sclk && !in_ready));

  // R10: when not busy the block is able to take a byte
  a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);

endmodule

// File: tb/test_disp_cmd_seq.sv
module test_disp_cmd_seq;

  localparam int H  = 2;
  localparam int RL = 30;
  localparam int RH = 20;
  localparam int BT = 16 * H;
  localparam int BE = 17 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic late_mode = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_first = 1'b0;
  logic in_last = 1'b0;
  logic in_pix = 1'b0;
  logic in_ready, spi_sclk, spi_mosi, spi_cs_n, disp_dc, disp_rst_n, busy;

  always #5 clk = ~clk;

  disp_cmd_seq #(.HALF_CYC(H), .RST_LOW_CYC(RL), .RST_HOLD_CYC(RH)) i_disp_cmd_seq (
    .clk(clk), .rst_n(rst_n), .late_mode(late_mode), .in_valid(in_valid),
    .in_data(in_data), .in_first(in_first), .in_last(in_last), .in_pix(in_pix),
    .in_ready(in_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .disp_dc(disp_dc), .disp_rst_n(disp_rst_n), .busy(busy)
  );

  int checks = 0;
  int failures = 0;
  bit cmp_en = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: time since acceptance drives everything.
  int   mk = 0;        // clock edges since reset release
  int   m_t = -1;      // cycles into current byte, -1 when none
  bit   m_open = 0;
  bit   m_last = 0;
  bit   m_late = 0;
  bit   m_pix = 0;
  bit   m_dc = 0;
  logic [7:0] m_data = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      mk = 0; m_t = -1; m_open = 0; m_last = 0; m_late = 0; m_pix = 0; m_dc = 0;
    end else begin
      bit idle_pre;
      idle_pre = (mk >= RL + RH) && (m_t < 0);
      if (m_t >= 0) begin
        m_t++;
        if (m_t == BE) begin
          m_t = -1;
          if (m_last) m_open = 0;
        end
      end
      if (idle_pre && in_valid && (in_first || m_open)) begin
        if (in_first) begin
          m_late = late_mode;
          m_pix = in_pix;
          m_dc = in_pix ? 1'b1 : 1'b0;
        end else begin
          m_dc = m_pix ? 1'b1 : (m_late ? 1'b0 : 1'b1);
        end
        m_t = 0;
        m_open = 1;
        m_last = in_last;
        m_data = in_data;
      end
      if (mk < 1000000) mk++;
    end
  end

  // Per-cycle comparison and serial byte monitor.
  bit prev_sclk = 0;
  int nbits = 0;
  logic [7:0] sh = 8'h00;
  bit cap_dc = 0;
  logic [8:0] cap_q[$];
  logic [8:0] exp_q[$];

  always @(negedge clk) begin
    if (cmp_en) begin
      bit e_sclk;
      e_sclk = (m_t >= 0) && (m_t < BT) && (((m_t / H) % 2) == 1);
      chk(disp_rst_n == (mk >= RL), "R1 disp_rst_n", disp_rst_n, mk >= RL);
      chk(in_ready == ((mk >= RL + RH) && (m_t < 0)), "R11 in_ready", in_ready,
          (mk >= RL + RH) && (m_t < 0));
      chk(busy == !((mk >= RL + RH) && (m_t < 0) && !m_open), "R10 busy", busy,
          !((mk >= RL + RH) && (m_t < 0) && !m_open));
      chk(spi_cs_n == !m_open, "R7 spi_cs_n", spi_cs_n, !m_open);
      chk(spi_sclk == e_sclk, "R6 spi_sclk", spi_sclk, e_sclk);
      if (m_t >= 0 && m_t < BT)
        chk(spi_mosi == m_data[7 - m_t / (2 * H)], "R6 spi_mosi", spi_mosi,
            m_data[7 - m_t / (2 * H)]);
      chk(disp_dc == m_dc, "R8 disp_dc", disp_dc, m_dc);
      if (spi_sclk && !prev_sclk) begin
        if (nbits == 0) cap_dc = disp_dc;
        sh = {sh[6:0], spi_mosi};
        nbits++;
        if (nbits == 8) begin
          cap_q.push_back({cap_dc, sh});
          nbits = 0;
        end
      end
    end
    prev_sclk = spi_sclk;
  end

  // Bench-side transaction tracking for expected DC per byte.
  bit t_open = 0;
  bit t_late = 0;
  bit t_pix = 0;

  task automatic send(input logic [7:0] d, input bit first, input bit last, input bit pix);
    bit taken;
    bit e_dc;
    @(negedge clk);
    in_valid = 1; in_data = d; in_first = first; in_last = last; in_pix = pix;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0; in_pix = 0;
    taken = first || t_open;
    if (taken) begin
      if (first) begin
        t_late = late_mode;
        t_pix = pix;
      end
      e_dc = t_pix ? 1'b1 : (first ? 1'b0 : !t_late);
      exp_q.push_back({e_dc, d});
      t_open = !last;
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic verify_log(input string tag);
    chk(cap_q.size() == exp_q.size(), {tag, " byte count"}, cap_q.size(), exp_q.size());
    if (cap_q.size() == exp_q.size())
      foreach (exp_q[i])
        chk(cap_q[i] == exp_q[i], {tag, " dc/byte"}, cap_q[i], exp_q[i]);
    cap_q.delete();
    exp_q.delete();
  endtask

  bit wd_hit = 0;

  initial begin
    fork
      begin : body
        repeat (3) @(negedge clk);
        // Reset state, R1 R10 R11 R7
        chk(disp_rst_n == 0, "R1 reset low", disp_rst_n, 0);
        chk(busy == 1, "R10 busy in reset", busy, 1);
        chk(in_ready == 0, "R11 not ready in reset", in_ready, 0);
        chk(spi_cs_n == 1, "R7 cs idle", spi_cs_n, 1);
        rst_n = 1;
        cmp_en = 1;
        begin
          int n;
          n = 0;
          while (!disp_rst_n) begin @(negedge clk); n++; end
          chk(n == RL, "R1 low width", n, RL);
          n = 0;
          while (!in_ready) begin @(negedge clk); n++; end
          chk(n == RH, "R1 hold width", n, RH);
        end

        // Single-byte command, R2
        late_mode = 0;
        send(8'hAF, 1, 1, 0);
        wait_idle();
        verify_log("R2 single opcode");

        // Opcode plus parameters, late off: R2 R3
        send(8'h81, 1, 0, 0);
        send(8'h7F, 0, 0, 0);
        send(8'h3C, 0, 1, 0);
        wait_idle();
        verify_log("R3 params dc high");

        // Late mode sampled at opening byte: R4
        late_mode = 1;
        send(8'h21, 1, 0, 0);
        late_mode = 0;
        send(8'h00, 0, 0, 0);
        send(8'h7F, 0, 1, 0);
        wait_idle();
        verify_log("R4 late params dc low");

        // Pixel transaction: R5
        late_mode = 1;
        send(8'h55, 1, 0, 1);
        send(8'hAA, 0, 0, 0);
        send(8'h0F, 0, 0, 0);
        send(8'hF0, 0, 1, 0);
        wait_idle();
        late_mode = 0;
        verify_log("R5 pixel dc high");

        // Stray non-opening byte outside a transaction: R9
        send(8'h99, 0, 1, 0);
        repeat (BE + 4) begin
          @(negedge clk);
          chk(spi_cs_n == 1 && spi_sclk == 0, "R9 stray byte quiet", {spi_cs_n, spi_sclk}, 2'b10);
        end
        verify_log("R9 stray byte dropped");

        // Gap between bytes keeps CS low: R7 R10
        send(8'hB0, 1, 0, 0);
        while (!in_ready) @(negedge clk);
        repeat (7) begin
          @(negedge clk);
          chk(spi_cs_n == 0, "R7 cs held in gap", spi_cs_n, 0);
          chk(busy == 1, "R10 busy in gap", busy, 1);
        end
        send(8'h12, 0, 1, 0);
        wait_idle();
        chk(spi_cs_n == 1, "R7 cs released", spi_cs_n, 1);
        chk(busy == 0, "R10 idle after close", busy, 0);
        verify_log("R3 gap transaction");

        // Back-to-back minimum spacing: R11 R6
        begin
          int t0;
          int t1;
          t0 = 0; t1 = 0;
          @(negedge clk);
          in_valid = 1; in_data = 8'hC3; in_first = 1; in_last = 0;
          @(negedge clk);
          in_first = 0; in_data = 8'h3C; in_last = 1;
          while (!in_ready) begin @(negedge clk); t0++; end
          @(negedge clk);
          in_valid = 0; in_last = 0;
          t1 = t0 + 1;
          chk(t1 == BE + 1, "R11 byte spacing", t1, BE + 1);
          exp_q.push_back({1'b0, 8'hC3});
          exp_q.push_back({1'b1, 8'h3C});
          wait_idle();
          verify_log("R6 back-to-back bytes");
        end
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired R11 actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule